// File: doc/BRIEF.md
# Outbound Window Address Translator

This block maps a local address that falls inside a fixed outbound region onto a 64-bit bus address. The region is cut into a row of windows that all have the same size, and each window carries its own programmable upper address. A single 3-bit size code sets the size of every window. Software programs the size code, the window entries and a global translation switch through a small register port with word addresses.

On the lookup side the block takes a 32-bit address together with a valid strobe. One clock later it returns the translated 64-bit address and a hit flag. A miss returns an all-zero address. A miss arises when the global switch is off, when the address lies below the region base or past the last window, or when the selected window is switched off.

The region base is a parameter and has to be aligned to 128 MB, the largest window size.

Top module: `ob_xlate_win`

## Requirements
- R1: After reset every register reads zero, `xo_valid` is low and no lookup hits until software programs the block.
- R2: Register map, word offsets on `reg_addr`: control at 0x004, where only bit 1 is stored (the translation enable) and every other bit reads zero; size at 0x030, where only bits [2:0] are stored; window n lower entry at 0x200 + 8n and upper entry at 0x204 + 8n, all 32 bits stored. Any other offset, including window offsets at or beyond NUM_WIN, reads zero, and a write to it changes nothing.
- R3: The size code k gives every window a size of 2^(20+k) bytes. A change of the code takes effect from the next lookup onward.
- R4: For an address A in range, the window index is (A − REGION_BASE) >> (20+k). The result is {upper entry, (lower entry with its low 20+k bits cleared) OR ((A − REGION_BASE) mod window size)}.
- R5: Bit 0 of a window's lower entry enables that window. A lookup that selects a disabled window misses.
- R6: While control bit 1 is clear, every lookup misses.
- R7: An address below REGION_BASE, or one whose window index is NUM_WIN or larger, misses.
- R8: `xo_valid` follows `xl_valid` by exactly one clock, so back-to-back lookups are accepted on every cycle. A result with `xo_hit` low carries an address of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| xl_valid | input | 1 | Lookup request strobe |
| xl_addr | input | 32 | Local address to translate |
| xo_valid | output | 1 | Lookup result valid |
| xo_hit | output | 1 | Translation hit |
| xo_addr | output | 64 | Translated bus address, zero on miss |

## Verification
The bench builds the block with NUM_WIN = 8 and REGION_BASE = 0x5000_0000. Eight windows make the end of the region close: with 1 MB windows, an address 8 MB above the base already exercises the out-of-range miss, and the offset of window 8 (0x240) becomes an unmapped register whose writes must be dropped. The same windows are then swept with size codes 0, 3 and 7. The largest windows push the index computation across high address bits, and those lookups run back to back into a scoreboard.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;

    localparam int UNIT_SHIFT = 20;          // 1 MB base unit
    localparam int SIZE_W     = 3;

    localparam logic [11:0] OFS_CTRL = 12'h004;
    localparam logic [11:0] OFS_SIZE = 12'h030;
    localparam logic [11:0] OFS_WIN  = 12'h200;
    localparam int          CTRL_EN_BIT = 1;

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
    } win_regs_t;

    typedef struct packed {
        logic        hit;
        logic [63:0] addr;
    } xl_res_t;

    function automatic logic [5:0] win_shift(input logic [SIZE_W-1:0] k);
        return 6'(UNIT_SHIFT) + 6'(k);
    endfunction

    function automatic logic [31:0] off_mask(input logic [SIZE_W-1:0] k);
        return (32'd1 << win_shift(k)) - 32'd1;
    endfunction

endpackage

// File: rtl/ob_xlate_regs.sv
module ob_xlate_regs
    import ob_xlate_pkg::*;
#(
    parameter int NUM_WIN = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_we,
    input  logic [11:0]              reg_addr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    output logic                     ctl_en,
    output logic [SIZE_W-1:0]        size_q,
    output win_regs_t [NUM_WIN-1:0]  win_q
);
    localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int WIN_END = int'(OFS_WIN) + 8 * NUM_WIN;

    logic [11:0]      win_rel;
    logic             in_win;
    logic [IDX_W-1:0] win_sel;

    assign win_rel = reg_addr - OFS_WIN;
    assign in_win  = (int'(reg_addr) >= int'(OFS_WIN)) && (int'(reg_addr) < WIN_END)
                     && (reg_addr[1:0] == 2'b00);
    assign win_sel = win_rel[IDX_W+2:3];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en <= 1'b0;
            size_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == OFS_CTRL) ctl_en <= reg_wdata[CTRL_EN_BIT];
            if (reg_addr == OFS_SIZE) size_q <= reg_wdata[SIZE_W-1:0];
        end
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                win_q[i] <= '0;
            end else if (reg_we && in_win && (win_sel == IDX_W'(i))) begin
                if (reg_addr[2]) win_q[i].hi <= reg_wdata;
                else             win_q[i].lo <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CTRL) begin
            reg_rdata[CTRL_EN_BIT] = ctl_en;
        end else if (reg_addr == OFS_SIZE) begin
            reg_rdata[SIZE_W-1:0] = size_q;
        end else if (in_win) begin
            reg_rdata = reg_addr[2] ? win_q[win_sel].hi : win_q[win_sel].lo;
        end
    end

    // R2: a write to the size register lands in the next cycle
    a_r2_size_write: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_SIZE) |=> (size_q == $past(reg_wdata[SIZE_W-1:0])));

    // R2: control write sets the enable from bit 1 only
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_CTRL) |=> (ctl_en == $past(reg_wdata[CTRL_EN_BIT])));

    // R2: without a write the settings hold still
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> ($stable(size_q) && $stable(ctl_en)));

endmodule

// File: rtl/ob_xlate_calc.sv
module ob_xlate_calc
    import ob_xlate_pkg::*;
#(
    parameter int          NUM_WIN     = 32,
    parameter logic [31:0] REGION_BASE = 32'h5000_0000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ctl_en,
    input  logic [SIZE_W-1:0]        size_q,
    input  win_regs_t [NUM_WIN-1:0]  win_q,
    input  logic                     xl_valid,
    input  logic [31:0]              xl_addr,
    output logic                     xo_valid,
    output xl_res_t                  xo_res
);
    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [32:0]      rel_w;
    logic             below;
    logic [31:0]      idx_full;
    logic             in_range;
    logic [IDX_W-1:0] win_idx;
    win_regs_t        sel;
    logic [31:0]      mask;
    xl_res_t          res_c;

    always_comb begin
        rel_w    = {1'b0, xl_addr} - {1'b0, REGION_BASE};
        below    = rel_w[32];
        idx_full = rel_w[31:0] >> win_shift(size_q);
        in_range = !below && (idx_full < 32'(NUM_WIN));
        win_idx  = idx_full[IDX_W-1:0];
        sel      = win_q[win_idx];
        mask     = off_mask(size_q);
        res_c.hit  = ctl_en && in_range && sel.lo[0];
        res_c.addr = res_c.hit ? {sel.hi, (sel.lo & ~mask) | (rel_w[31:0] & mask)} : 64'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xo_valid <= 1'b0;
            xo_res   <= '0;
        end else begin
            xo_valid <= xl_valid;
            xo_res   <= xl_valid ? res_c : '0;
        end
    end

    // R8: one-cycle latency, no bubbles
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (rst)
        xl_valid |=> xo_valid);
    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        !xl_valid |=> !xo_valid);
    // R8: a miss returns a zero address
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (xo_valid && !xo_res.hit) |-> (xo_res.addr == 64'd0));
    // R6: translation switched off means no hit
    a_r6_off_miss: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && !ctl_en) |=> !xo_res.hit);
    // R7: below the region base means no hit
    a_r7_below: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && xl_addr < REGION_BASE) |=> !xo_res.hit);
    // R4: the lowest 1 MB of offset always passes straight through on a hit
    a_r4_low_offset: assert property (@(posedge clk) disable iff (rst)
        xl_valid |=> (!xo_res.hit ||
                      xo_res.addr[19:0] == $past(xl_addr[19:0] - REGION_BASE[19:0])));

endmodule

// File: rtl/ob_xlate_win.sv
module ob_xlate_win
    import ob_xlate_pkg::*;
#(
    parameter int          NUM_WIN     = 32,
    parameter logic [31:0] REGION_BASE = 32'h5000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        xl_valid,
    input  logic [31:0] xl_addr,
    output logic        xo_valid,
    output logic        xo_hit,
    output logic [63:0] xo_addr
);
    logic                    ctl_en;
    logic [SIZE_W-1:0]       size_q;
    win_regs_t [NUM_WIN-1:0] win_q;
    xl_res_t                 xo_res;

    ob_xlate_regs #(.NUM_WIN(NUM_WIN)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctl_en    (ctl_en),
        .size_q    (size_q),
        .win_q     (win_q)
    );

    ob_xlate_calc #(.NUM_WIN(NUM_WIN), .REGION_BASE(REGION_BASE)) i_calc (
        .clk      (clk),
        .rst      (rst),
        .ctl_en   (ctl_en),
        .size_q   (size_q),
        .win_q    (win_q),
        .xl_valid (xl_valid),
        .xl_addr  (xl_addr),
        .xo_valid (xo_valid),
        .xo_res   (xo_res)
    );

    assign xo_hit  = xo_res.hit;
    assign xo_addr = xo_res.addr;

    // R1: nothing valid in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> !xo_valid);

endmodule

// File: tb/test_ob_xlate_win.sv
`timescale 1ns/1ps
module test_ob_xlate_win;
    localparam int          NW   = 8;
    localparam logic [31:0] BASE = 32'h5000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xl_valid = 1'b0;
    logic [31:0] xl_addr = '0;
    logic        xo_valid;
    logic        xo_hit;
    logic [63:0] xo_addr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // shadow of programmed state, kept from the register map rules
    logic        sh_en = 1'b0;
    logic [2:0]  sh_size = '0;
    logic [31:0] sh_lo [NW];
    logic [31:0] sh_hi [NW];

    logic        q_hit [$];
    logic [63:0] q_addr [$];
    string       q_tag [$];

    always #4 clk = ~clk;

    ob_xlate_win #(.NUM_WIN(NW), .REGION_BASE(BASE)) i_ob_xlate_win (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_valid(xl_valid),
        .xl_addr(xl_addr), .xo_valid(xo_valid), .xo_hit(xo_hit), .xo_addr(xo_addr)
    );

    function automatic void model(input logic [31:0] a, output logic hit, output logic [63:0] ad);
        logic [31:0] rel, mask, idx;
        int sh;
        hit = 1'b0;
        ad  = 64'd0;
        if (a < BASE || !sh_en) return;
        rel  = a - BASE;
        sh   = 20 + int'(sh_size);
        idx  = rel >> sh;
        if (idx >= NW) return;
        if (!sh_lo[idx][0]) return;
        mask = (32'd1 << sh) - 32'd1;
        hit  = 1'b1;
        ad   = {sh_hi[idx], (sh_lo[idx] & ~mask) | (rel & mask)};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic wr_win(input int n, input logic [31:0] lo, input logic [31:0] hi);
        wr(12'(12'h200 + 8 * n), lo);
        wr(12'(12'h204 + 8 * n), hi);
        sh_lo[n] = lo;
        sh_hi[n] = hi;
    endtask

    task automatic look(input logic [31:0] a, input string tag);
        logic h;
        logic [63:0] ad;
        @(negedge clk);
        model(a, h, ad);
        xl_valid = 1'b1;
        xl_addr  = a;
        q_hit.push_back(h);
        q_addr.push_back(ad);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        xl_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && xo_valid) begin
            if (q_hit.size() == 0) begin
                check(1'b0, "R8 unexpected result", 64'(xo_valid), 64'd0);
            end else begin
                logic        eh;
                logic [63:0] ea;
                string       t;
                eh = q_hit.pop_front();
                ea = q_addr.pop_front();
                t  = q_tag.pop_front();
                check(xo_hit == eh, {t, " hit"}, 64'(xo_hit), 64'(eh));
                check(xo_addr == ea, {t, " addr"}, xo_addr, ea);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <= 20000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) begin sh_lo[i] = '0; sh_hi[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check(xo_valid == 1'b0, "R1 xo_valid", 64'(xo_valid), 64'd0);
        rd(12'h004, 32'd0, "R1 ctrl");
        rd(12'h030, 32'd0, "R1 size");
        rd(12'h200, 32'd0, "R1 win0 lo");
        rd(12'h23C, 32'd0, "R1 win7 hi");
        look(BASE + 32'h10, "R1 no hit after reset");
        idle(2);

        // program windows; window 3 disabled
        for (int n = 0; n < NW; n++)
            wr_win(n, (32'h8000_0000 + 32'(n) * 32'h0800_0000) | 32'(n != 3),
                   32'h0000_0100 + 32'(n));

        // R2 register map
        rd(12'h208, 32'h8800_0001, "R2 win1 lo");
        rd(12'h21C, 32'h0000_0103, "R2 win3 hi");
        wr(12'h240, 32'hDEAD_BEEF);
        rd(12'h240, 32'd0, "R2 window past NUM_WIN");
        wr(12'h100, 32'h1234_5678);
        rd(12'h100, 32'd0, "R2 unmapped");
        rd(12'h200, 32'h8000_0001, "R2 win0 unchanged");
        wr(12'h030, 32'hFFFF_FFF8);
        rd(12'h030, 32'd0, "R2 size only low bits");

        // R6 translation disabled
        look(BASE + 32'h0001_2345, "R6 disabled miss");
        idle(2);
        wr(12'h004, 32'hFFFF_FFFF);
        sh_en = 1'b1;
        rd(12'h004, 32'h0000_0002, "R2 ctrl bit1 only");

        // R3/R4 1 MB windows, back to back (R8)
        look(BASE + 32'h0001_2345, "R4 k0 win0");
        look(BASE + 32'h0010_0ABC, "R4 k0 win1");
        look(BASE + 32'h002F_FFFF, "R4 k0 win2 top");
        look(BASE + 32'h0030_0000, "R5 win3 disabled");
        look(BASE + 32'h007F_FFFF, "R4 k0 win7 last byte");
        look(BASE + 32'h0080_0000, "R7 index NUM_WIN");
        look(BASE - 32'd1, "R7 below base");
        idle(3);

        // R3 8 MB windows
        wr(12'h030, 32'd3);
        sh_size = 3'd3;
        look(BASE + 32'h0012_3456, "R3 k3 win0");
        look(BASE + 32'h02F0_0010, "R3 k3 win5");
        look(BASE + 32'h0400_0000, "R7 k3 past end");
        idle(3);

        // R3 128 MB windows
        wr(12'h030, 32'd7);
        sh_size = 3'd7;
        look(BASE + 32'h07FF_FFF0, "R3 k7 win0");
        look(BASE + 32'h3812_3456, "R3 k7 win7");
        look(BASE + 32'h1A00_0000, "R5 k7 win3 disabled");
        idle(3);

        // R6 turn off again
        wr(12'h004, 32'd0);
        sh_en = 1'b0;
        look(BASE + 32'h0012_3456, "R6 disabled again");
        idle(3);

        check(q_hit.size() == 0, "R8 results outstanding", 64'(q_hit.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule